// File: doc/BRIEF.md
# Mode-Filtered Performance Event Counter Bank

The block holds a bank of 64-bit hardware event counters, each paired with a 64-bit selector word. A counter advances by one on a clock edge where its event pulse is present, its selector is not all zeros, and the selector does not inhibit counting in the privilege mode the hart is currently in. Five inhibit bits in the selector cover machine, supervisor, user, virtual-supervisor and virtual-user modes. The selector's top bit is a sticky overflow flag. Hardware sets it when its counter wraps past all ones. It also acts as the interrupt disable for that counter: a wrap raises a one-cycle overflow request only when the flag was clear beforehand.

Software reaches every counter and selector through a 32-bit access port. Low and high halves are written and read separately, and a write never counts as an overflow. The host core routes the overflow requests into its local interrupt logic. It also reads the flags as a compact vector.

Top module: `hpm_counter_bank`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it is released, every counter and selector reads zero and no overflow request is high.
- R2: On a clock edge where a counter is qualified (event pulse high, selector nonzero, current mode not inhibited), the counter holds its old value plus one after that edge.
- R3: A counter whose whole 64-bit selector is zero never changes, except by a software write.
- R4: Selector bit 62 inhibits counting in machine mode, bit 61 in supervisor mode, bit 60 in user mode, bit 59 in virtual-supervisor mode and bit 58 in virtual-user mode. The mode is decoded from `priv_lvl_i` (00 user, 01 supervisor, 11 machine, 10 treated as machine) and `virt_i` (1 selects the virtual form of user or supervisor, and is ignored in machine mode).
- R5: With bits 62 to 58 clear, a qualified event is counted in each of the five modes.
- R6: An increment from all ones leaves the counter at zero, counting continues from there, and selector bit 63 reads one after that edge.
- R7: A wrap drives the counter's bit of `ovf_req_o` high for exactly the one cycle after the wrapping edge, and only if selector bit 63 was zero before that edge. A wrap with bit 63 already set gives no request.
- R8: Selector bit 63 stays set until software writes the selector's high half. That write loads bit 63 from `csr_wdata_i[31]`, and `ovf_flag_o` mirrors bit 63.
- R9: Software writes to a counter never set bit 63 and never raise a request, even when they load all ones. A counter write in the same cycle as a qualified event loads the written half and suppresses that increment.
- R10: Access port: `csr_is_cnt_i` 1 targets a counter and 0 a selector, `csr_hi_i` 1 targets bits 63:32 and 0 bits 31:0, and `csr_idx_i` value FIRST_IDX+k targets counter k (3 to 31 by default). `csr_rdata_i` returns the addressed half in the same cycle. Indices outside the range ignore writes and read zero.
- R11: Selector bits 57 and 56 always read zero, whatever is written to them.
- R12: A high-half selector write in the same cycle as a wrap decides bit 63 (software wins), and the request for that wrap still follows the flag value from before the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to clk |
| evt_i | input | NUM_CNT | Per-counter event pulse |
| priv_lvl_i | input | 2 | Current privilege level (00 U, 01 S, 11 M) |
| virt_i | input | 1 | Virtualized mode flag |
| csr_we_i | input | 1 | Write strobe for the access port |
| csr_is_cnt_i | input | 1 | 1 selects a counter, 0 a selector |
| csr_hi_i | input | 1 | 1 selects bits 63:32, 0 bits 31:0 |
| csr_idx_i | input | IDX_W | Counter index |
| csr_wdata_i | input | 32 | Write data |
| csr_rdata_o | output | 32 | Read data for the addressed half, combinational |
| cnt_o | output | NUM_CNT*64 | All counter values, counter k at bits 64k+63:64k |
| sel_o | output | NUM_CNT*64 | All selector values, same packing |
| ovf_flag_o | output | NUM_CNT | Overflow flag (selector bit 63) per counter |
| ovf_req_o | output | NUM_CNT | One-cycle overflow request per counter |

## Verification
Counters, selectors and flags are registered, so any effect of an event, mode or write presented before a rising edge shows on the outputs right after that edge. An overflow request appears in the cycle that follows the wrapping edge, together with the newly set flag. Read data is combinational and tracks the current state and address. The bench drives inputs on falling edges and samples a short delay after each rising edge. At that point a behavioural model has applied the same edge. Every counter, selector, request and the read data are compared there in every cycle, so a result that comes one cycle early or late fails.

// File: rtl/hpm_pkg.sv
package hpm_pkg;
  localparam int HALF_W    = 32;
  localparam int WORD_W    = 2 * HALF_W;
  localparam int OF_POS    = WORD_W - 1;
  localparam int INH_HI    = WORD_W - 2;
  localparam int INH_LO    = WORD_W - 6;
  localparam int RSV_HI    = WORD_W - 7;
  localparam int RSV_LO    = WORD_W - 8;
  localparam int NUM_MODES = INH_HI - INH_LO + 1;

  typedef enum logic [1:0] {
    LVL_USER  = 2'b00,
    LVL_SUPER = 2'b01,
    LVL_RSVD  = 2'b10,
    LVL_MACH  = 2'b11
  } priv_lvl_e;

  typedef struct packed {
    logic cnt_lo;
    logic cnt_hi;
    logic sel_lo;
    logic sel_hi;
  } wr_strobe_t;
endpackage

// File: rtl/hpm_mode_decode.sv
// Turns the privilege level and virtualization flag into a one-hot mask
// aligned with the selector's inhibit field (MSB = machine, LSB = virtual user).
module hpm_mode_decode
  import hpm_pkg::*;
(
  input  logic [1:0]           priv_lvl_i,
  input  logic                 virt_i,
  output logic [NUM_MODES-1:0] mode_mask_o
);
  localparam int M_BIT  = NUM_MODES - 1;
  localparam int S_BIT  = NUM_MODES - 2;
  localparam int U_BIT  = NUM_MODES - 3;
  localparam int VS_BIT = NUM_MODES - 4;
  localparam int VU_BIT = NUM_MODES - 5;

  priv_lvl_e lvl;
  assign lvl = priv_lvl_e'(priv_lvl_i);

  always_comb begin
    mode_mask_o = '0;
    case (lvl)
      LVL_USER: begin
        if (virt_i) mode_mask_o[VU_BIT] = 1'b1;
        else        mode_mask_o[U_BIT]  = 1'b1;
      end
      LVL_SUPER: begin
        if (virt_i) mode_mask_o[VS_BIT] = 1'b1;
        else        mode_mask_o[S_BIT]  = 1'b1;
      end
      default: mode_mask_o[M_BIT] = 1'b1;
    endcase
  end
endmodule

// File: rtl/hpm_counter_slice.sv
// One counter with its selector word, overflow flag and request register.
module hpm_counter_slice
  import hpm_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 evt_i,
  input  logic [NUM_MODES-1:0] mode_mask_i,
  input  wr_strobe_t           wr_i,
  input  logic [HALF_W-1:0]    wdata_i,
  output logic [WORD_W-1:0]    cnt_o,
  output logic [WORD_W-1:0]    sel_o,
  output logic                 req_o
);
  logic [WORD_W-1:0] cnt_q, cnt_d;
  logic [WORD_W-1:0] sel_q, sel_d;
  logic              req_q, req_d;
  logic              sel_nonzero, inhibited, count_en;
  logic              cnt_wr, cnt_ce, sel_ce, wrap;

  // qualification of one increment
  assign sel_nonzero = |sel_q;
  assign inhibited   = |(sel_q[INH_HI:INH_LO] & mode_mask_i);
  assign count_en    = evt_i & sel_nonzero & ~inhibited;

  // software writes take the counter; only a hardware increment wraps
  assign cnt_wr = wr_i.cnt_lo | wr_i.cnt_hi;
  assign wrap   = count_en & ~cnt_wr & (&cnt_q);
  assign cnt_ce = cnt_wr | count_en;
  assign sel_ce = wr_i.sel_lo | wr_i.sel_hi | wrap;

  always_comb begin
    cnt_d = cnt_q;
    if (wr_i.cnt_lo)      cnt_d[HALF_W-1:0]      = wdata_i;
    else if (wr_i.cnt_hi) cnt_d[WORD_W-1:HALF_W] = wdata_i;
    else if (count_en)    cnt_d                  = cnt_q + 1'b1;
  end

  always_comb begin
    sel_d = sel_q;
    if (wrap) sel_d[OF_POS] = 1'b1;
    if (wr_i.sel_lo) sel_d[HALF_W-1:0] = wdata_i;
    if (wr_i.sel_hi) begin
      sel_d[WORD_W-1:HALF_W] = wdata_i;   // software wins the flag bit
      sel_d[RSV_HI:RSV_LO]   = '0;
    end
  end

  assign req_d = wrap & ~sel_q[OF_POS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_ce) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sel_q <= '0;
    else if (sel_ce) sel_q <= sel_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= req_d;
  end

  assign cnt_o = cnt_q;
  assign sel_o = sel_q;
  assign req_o = req_q;

  // R3: an all-zero selector freezes the counter apart from software writes
  assert_zero_sel_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q == '0 && !cnt_wr) |=> (cnt_q == $past(cnt_q)));

  // R6: a wrapping increment lands on zero
  assert_wrap_to_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (cnt_q == '0));

  // R7: a request follows a flag that was clear before the wrapping edge
  assert_req_needs_clear_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req_o |-> ($past(sel_q[OF_POS]) == 1'b0 && $past(evt_i)));

  // R8: the flag only falls through a high-half selector write
  assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q[OF_POS] && !wr_i.sel_hi) |=> sel_q[OF_POS]);

  // R9: a counter write is never followed by a request
  assert_sw_write_no_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> !req_o);

  // R11: reserved selector bits stay zero
  assert_reserved_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    sel_q[RSV_HI:RSV_LO] == '0);
endmodule

// File: rtl/hpm_csr_read.sv
// Combinational read mux for the 32-bit access port.
module hpm_csr_read
  import hpm_pkg::*;
#(
  parameter int FIRST_IDX = 3,
  parameter int NUM_CNT   = 29,
  parameter int IDX_W     = 5
) (
  input  logic [NUM_CNT*WORD_W-1:0] cnt_i,
  input  logic [NUM_CNT*WORD_W-1:0] sel_i,
  input  logic [IDX_W-1:0]          idx_i,
  input  logic                      is_cnt_i,
  input  logic                      hi_i,
  output logic [HALF_W-1:0]         rdata_o
);
  always_comb begin
    rdata_o = '0;
    for (int k = 0; k < NUM_CNT; k++) begin
      if (idx_i == IDX_W'(FIRST_IDX + k)) begin
        if (is_cnt_i) rdata_o = hi_i ? cnt_i[k*WORD_W+HALF_W +: HALF_W] : cnt_i[k*WORD_W +: HALF_W];
        else          rdata_o = hi_i ? sel_i[k*WORD_W+HALF_W +: HALF_W] : sel_i[k*WORD_W +: HALF_W];
      end
    end
  end
endmodule

// File: rtl/hpm_counter_bank.sv
module hpm_counter_bank
  import hpm_pkg::*;
#(
  parameter int FIRST_IDX = 3,
  parameter int NUM_CNT   = 29,
  parameter int IDX_W     = 5
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_CNT-1:0]        evt_i,
  input  logic [1:0]                priv_lvl_i,
  input  logic                      virt_i,
  input  logic                      csr_we_i,
  input  logic                      csr_is_cnt_i,
  input  logic                      csr_hi_i,
  input  logic [IDX_W-1:0]          csr_idx_i,
  input  logic [HALF_W-1:0]         csr_wdata_i,
  output logic [HALF_W-1:0]         csr_rdata_o,
  output logic [NUM_CNT*WORD_W-1:0] cnt_o,
  output logic [NUM_CNT*WORD_W-1:0] sel_o,
  output logic [NUM_CNT-1:0]        ovf_flag_o,
  output logic [NUM_CNT-1:0]        ovf_req_o
);
  localparam int STROBES = $bits(wr_strobe_t);

  logic [NUM_MODES-1:0]       mode_mask;
  logic [NUM_CNT*STROBES-1:0] all_strobes;

  hpm_mode_decode u_mode (
    .priv_lvl_i  (priv_lvl_i),
    .virt_i      (virt_i),
    .mode_mask_o (mode_mask)
  );

  for (genvar k = 0; k < NUM_CNT; k++) begin : g_slice
    logic       hit;
    wr_strobe_t wr;

    assign hit       = csr_we_i & (csr_idx_i == IDX_W'(FIRST_IDX + k));
    assign wr.cnt_lo = hit &  csr_is_cnt_i & ~csr_hi_i;
    assign wr.cnt_hi = hit &  csr_is_cnt_i &  csr_hi_i;
    assign wr.sel_lo = hit & ~csr_is_cnt_i & ~csr_hi_i;
    assign wr.sel_hi = hit & ~csr_is_cnt_i &  csr_hi_i;
    assign all_strobes[k*STROBES +: STROBES] = wr;

    hpm_counter_slice u_slice (
      .clk         (clk),
      .rst_n       (rst_n),
      .evt_i       (evt_i[k]),
      .mode_mask_i (mode_mask),
      .wr_i        (wr),
      .wdata_i     (csr_wdata_i),
      .cnt_o       (cnt_o[k*WORD_W +: WORD_W]),
      .sel_o       (sel_o[k*WORD_W +: WORD_W]),
      .req_o       (ovf_req_o[k])
    );

    assign ovf_flag_o[k] = sel_o[k*WORD_W + OF_POS];
  end

  hpm_csr_read #(
    .FIRST_IDX (FIRST_IDX),
    .NUM_CNT   (NUM_CNT),
    .IDX_W     (IDX_W)
  ) u_read (
    .cnt_i    (cnt_o),
    .sel_i    (sel_o),
    .idx_i    (csr_idx_i),
    .is_cnt_i (csr_is_cnt_i),
    .hi_i     (csr_hi_i),
    .rdata_o  (csr_rdata_o)
  );

  // R10: one port access touches at most one register half
  assert_single_target_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(all_strobes));

  // R1: no request in the first cycle after reset release
  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (ovf_req_o == '0));
endmodule

// File: tb/sim_hpm_counter_bank.sv
module sim_hpm_counter_bank;
  localparam int  CLK_PERIOD = 10;
  localparam int  NC         = 29;
  localparam int  FIRST      = 3;
  localparam int  WDOG_LIMIT = 20000;
  localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [NC-1:0]   evt;
  logic [1:0]      lvl;
  logic            virt;
  logic            we, is_cnt, hi;
  logic [4:0]      idx;
  logic [31:0]     wdata;
  logic [31:0]     rdata;
  logic [NC*64-1:0] cnt_v, sel_v;
  logic [NC-1:0]   flag_v, req_v;

  int    errors = 0;
  int    checks = 0;
  int    cycles = 0;
  bit    done   = 0;
  string tag    = "R1";

  logic [63:0] m_cnt [NC];
  logic [63:0] m_sel [NC];
  logic        m_req [NC];

  always #(CLK_PERIOD/2) clk = ~clk;

  hpm_counter_bank u0 (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .priv_lvl_i(lvl), .virt_i(virt),
    .csr_we_i(we), .csr_is_cnt_i(is_cnt), .csr_hi_i(hi), .csr_idx_i(idx),
    .csr_wdata_i(wdata), .csr_rdata_o(rdata), .cnt_o(cnt_v), .sel_o(sel_v),
    .ovf_flag_o(flag_v), .ovf_req_o(req_v)
  );

  function automatic int inh_bit(logic v, logic [1:0] l);
    if (l == 2'b01) return v ? 59 : 61;
    if (l == 2'b00) return v ? 58 : 60;
    return 62;
  endfunction

  function automatic logic [31:0] exp_rdata();
    for (int k = 0; k < NC; k++)
      if (int'(idx) == FIRST + k) begin
        if (is_cnt) return hi ? m_cnt[k][63:32] : m_cnt[k][31:0];
        return hi ? m_sel[k][63:32] : m_sel[k][31:0];
      end
    return 32'h0;
  endfunction

  // behavioural reference, one step per rising edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NC; k++) begin m_cnt[k] = '0; m_sel[k] = '0; m_req[k] = 0; end
    end else begin
      for (int k = 0; k < NC; k++) begin
        logic hit, en, cw, wr_ovf;
        logic [63:0] c, s;
        hit = we && (int'(idx) == FIRST + k);
        cw  = hit && is_cnt;
        c = m_cnt[k]; s = m_sel[k];
        en = evt[k] && (s != 0) && !s[inh_bit(virt, lvl)];
        wr_ovf = en && !cw && (c == ONES);
        m_req[k] = wr_ovf && !s[63];
        if (cw) begin
          if (hi) c[63:32] = wdata; else c[31:0] = wdata;
        end else if (en) c = c + 64'd1;
        if (wr_ovf) s[63] = 1'b1;
        if (hit && !is_cnt) begin
          if (hi) begin s[63:32] = wdata; s[57:56] = 2'b00; end
          else s[31:0] = wdata;
        end
        m_cnt[k] = c; m_sel[k] = s;
      end
    end
  end

  task automatic check(bit ok, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // compare every cycle, shortly after the edge
  always @(posedge clk) begin
    #2;
    if (!done) begin
      for (int k = 0; k < NC; k++) begin
        check(cnt_v[k*64 +: 64] === m_cnt[k], $sformatf("cnt[%0d]", FIRST + k), cnt_v[k*64 +: 64], m_cnt[k]);
        check(sel_v[k*64 +: 64] === m_sel[k], $sformatf("sel[%0d]", FIRST + k), sel_v[k*64 +: 64], m_sel[k]);
        check(flag_v[k] === m_sel[k][63], $sformatf("flag[%0d]", FIRST + k), 64'(flag_v[k]), 64'(m_sel[k][63]));
        check(req_v[k] === m_req[k], $sformatf("req[%0d]", FIRST + k), 64'(req_v[k]), 64'(m_req[k]));
      end
      check(rdata === exp_rdata(), "rdata R10", 64'(rdata), 64'(exp_rdata()));
    end
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles >= WDOG_LIMIT && !done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected<%0d", cycles, WDOG_LIMIT);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(bit c, bit h, int i, logic [31:0] d);
    @(negedge clk);
    we = 1; is_cnt = c; hi = h; idx = 5'(i); wdata = d;
    @(negedge clk);
    we = 0;
  endtask

  task automatic rd(bit c, bit h, int i);
    @(negedge clk);
    we = 0; is_cnt = c; hi = h; idx = 5'(i);
  endtask

  task automatic mode(logic [1:0] l, logic v);
    lvl = l; virt = v;
  endtask

  task automatic pulse(int k, int n);
    @(negedge clk);
    evt = '0; evt[k] = 1'b1;
    repeat (n) @(negedge clk);
    evt = '0;
  endtask

  initial begin
    rst_n = 0; evt = '0; lvl = 2'b11; virt = 0;
    we = 0; is_cnt = 0; hi = 0; idx = '0; wdata = '0;

    // R1: reset state
    idle(3);
    rst_n = 1;
    idle(2);

    // R3: zero selectors ignore events
    tag = "R3";
    evt = '1; idle(5); evt = '0;

    // R10: half accesses and out-of-range indices
    tag = "R10";
    wr(1, 0, 4, 32'h1234_5678);
    wr(1, 1, 4, 32'h9ABC_DEF0);
    rd(1, 0, 4); idle(1);
    rd(1, 1, 4); idle(1);
    wr(0, 0, 0, 32'hFFFF_FFFF);
    wr(1, 0, 2, 32'hFFFF_FFFF);
    rd(0, 0, 0); idle(1);
    wr(0, 0, 31, 32'h5);
    pulse(28, 3);
    rd(1, 0, 31); idle(1);

    // R2: increment under qualification
    tag = "R2";
    wr(0, 0, 3, 32'h1);
    mode(2'b11, 0);
    pulse(0, 4);
    evt = '1; idle(3); evt = '0;

    // R5: every mode counts with no inhibit
    tag = "R5";
    for (int m = 0; m < 5; m++) begin
      case (m)
        0: mode(2'b00, 0);
        1: mode(2'b01, 0);
        2: mode(2'b01, 1);
        3: mode(2'b00, 1);
        default: mode(2'b11, 1);
      endcase
      pulse(0, 2);
    end

    // R4: each inhibit bit against each mode
    tag = "R4";
    for (int b = 0; b < 5; b++) begin
      wr(0, 1, 3, 32'h1 << (30 - b));
      for (int m = 0; m < 5; m++) begin
        case (m)
          0: mode(2'b11, 0);
          1: mode(2'b01, 0);
          2: mode(2'b00, 0);
          3: mode(2'b01, 1);
          default: mode(2'b00, 1);
        endcase
        pulse(0, 2);
      end
    end
    mode(2'b10, 0); pulse(0, 2);
    mode(2'b11, 0);

    // R6: wrap to zero and keep counting
    tag = "R6";
    wr(0, 0, 5, 32'h1);
    wr(1, 1, 5, 32'hFFFF_FFFF);
    wr(1, 0, 5, 32'hFFFF_FFFD);
    pulse(2, 6);

    // R7: no request with the flag already set
    tag = "R7";
    wr(1, 1, 5, 32'hFFFF_FFFF);
    wr(1, 0, 5, 32'hFFFF_FFFE);
    pulse(2, 4);

    // R8: flag cleared by a high-half selector write, then rearmed
    tag = "R8";
    idle(3);
    wr(0, 0, 5, 32'h3);
    idle(2);
    wr(0, 1, 5, 32'h0);
    wr(1, 1, 5, 32'hFFFF_FFFF);
    wr(1, 0, 5, 32'hFFFF_FFFF);
    pulse(2, 2);
    wr(0, 1, 5, 32'h8000_0000);
    idle(2);

    // R9: software writes never overflow
    tag = "R9";
    wr(1, 1, 6, 32'hFFFF_FFFF);
    wr(1, 0, 6, 32'hFFFF_FFFF);
    idle(2);
    wr(0, 0, 6, 32'h1);
    @(negedge clk);
    evt[3] = 1; we = 1; is_cnt = 1; hi = 0; idx = 5'd6; wdata = 32'hFFFF_FFFF;
    @(negedge clk);
    we = 0; evt = '0;
    idle(2);

    // R11: reserved bits read zero
    tag = "R11";
    wr(0, 1, 7, 32'hFFFF_FFFF);
    rd(0, 1, 7); idle(2);

    // R12: selector write meets a wrap
    tag = "R12";
    wr(0, 0, 8, 32'h1);
    wr(1, 1, 8, 32'hFFFF_FFFF);
    wr(1, 0, 8, 32'hFFFF_FFFF);
    @(negedge clk);
    evt[5] = 1; we = 1; is_cnt = 0; hi = 1; idx = 5'd8; wdata = 32'h0;
    @(negedge clk);
    we = 0; evt = '0;
    idle(2);
    wr(1, 0, 8, 32'hFFFF_FFFF);
    wr(1, 1, 8, 32'hFFFF_FFFF);
    wr(0, 1, 8, 32'h8000_0000);
    @(negedge clk);
    evt[5] = 1; we = 1; is_cnt = 0; hi = 1; idx = 5'd8; wdata = 32'h0;
    @(negedge clk);
    we = 0; evt = '0;
    idle(2);

    // R2: mixed traffic
    tag = "R2 mixed";
    for (int k = 0; k < NC; k++) if (k % 3 != 0) wr(0, 0, FIRST + k, 32'(k));
    for (int t = 0; t < 400; t++) begin
      @(negedge clk);
      evt = NC'($urandom);
      lvl = 2'($urandom); virt = 1'($urandom);
      we = (($urandom % 8) == 0);
      is_cnt = 1'($urandom); hi = 1'($urandom);
      idx = 5'($urandom); wdata = ($urandom % 2) ? 32'hFFFF_FFFF : $urandom;
    end
    @(negedge clk);
    evt = '0; we = 0;
    idle(2);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule